// File: doc/BRIEF.md
# Time-Multiplexed NOR2 Netlist Evaluator

This block runs an arbitrary acyclic network of two-input NOR gates on a single shared NOR operator. Software-side logic first fills a gate table through a write port: each numbered entry names the two sources of that gate. A source is either one primary input bit or the result of a lower-numbered gate. A gate-count register says how many entries, starting at entry 0, make up the network. An output map says which gate result drives each bit of the output bus.

A start strobe captures the input vector. The block then evaluates one gate per clock in ascending index order and stores every result in a one-bit-per-gate value file, so later gates can read results produced earlier in the same run. After the last configured gate it latches the mapped results onto the output bus and pulses done. The results match those of a fully spatial gate array for the same table; only the number of cycles differs.

Top module: `nor2_eval`

## Requirements
- R1: A source selector is 7 bits wide. Bit 6 set means a gate result, taken from the gate whose number is in bits 5:0. Bit 6 clear means a primary input, whose number is in bits 3:0 (bits 5:4 are ignored). Each gate's result is the NOR of its two sources.
- R2: Gates 0 to N-1 are evaluated one per cycle in ascending order, where N is the gate count. A gate that names a lower-numbered gate sees that gate's result from the same run.
- R3: Start is accepted only when the block is idle and N is nonzero. The input vector is captured on the accepting edge, and later changes to the input pins do not affect that run.
- R4: After an accepting edge, busy is high for exactly N cycles. Done is then high for exactly one cycle, the cycle right after busy falls, and busy is low in that cycle.
- R5: A start strobe while busy is ignored. The run is neither restarted nor lengthened, and no second run follows.
- R6: The gate count resets to 0. An idle write of a value from 0 to 64 is stored, and a write of a larger value is ignored. While the count is 0, start is ignored: busy and done stay low.
- R7: Output bit k shows the result of the gate named in output-map slot k. The bus is loaded in the cycle done is high and holds until the next done. The map and the bus reset to zeros.
- R8: Writes to the gate table, the gate count and the output map are ignored while busy.
- R9: A mapped gate numbered N or higher is not evaluated. It shows the value it held from an earlier run, or 0 if it has not been evaluated since reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgGateWe | input | 1 | Gate-table write enable |
| cfgGateAddr | input | 6 | Gate number to write |
| cfgSrcA | input | 7 | First source selector |
| cfgSrcB | input | 7 | Second source selector |
| cfgCountWe | input | 1 | Gate-count write enable |
| cfgCountVal | input | 7 | New gate count |
| cfgMapWe | input | 1 | Output-map write enable |
| cfgMapSlot | input | 3 | Output bit to remap |
| cfgMapGate | input | 6 | Gate number for that output bit |
| start | input | 1 | Start strobe |
| inVec | input | 16 | Primary input vector |
| busy | output | 1 | Evaluation in progress |
| done | output | 1 | One-cycle completion pulse |
| outVec | output | 8 | Mapped gate results |

## Verification
The assertions check the sequencing on every cycle. They cover run length against the gate count, the one-cycle done pulse, the gate index stepping by one, the gate count holding still during a run, start being refused when the count is zero, and the output bus changing only when done is high. Whether the computed values are correct can only be shown by the bench's scenarios, which compare against a model of the network. These scenarios cover chained gates, the ignored upper input-index bits, unevaluated mapped gates, and input pins or configuration that change in the middle of a run.

// File: rtl/nor2_eval_pkg.sv
package nor2_eval_pkg;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } nor2SeqState_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic capture;  // latch the input vector
    logic evalEn;   // write the current gate result
    logic finish;   // load the output bus
    logic cfgLock;  // block configuration writes
  } nor2Strobes_t;

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/nor2_eval_operand.sv
module nor2_eval_operand #(
  parameter int NUM_GATES  = 64,
  parameter int NUM_INPUTS = 16,
  parameter int SW         = 6
) (
  input  logic [SW:0]             sel,
  input  logic [NUM_INPUTS-1:0]   inBits,
  input  logic [NUM_GATES-1:0]    gateBits,
  output logic                    bitOut
);
  localparam int GW = $clog2(NUM_GATES);
  localparam int IW = $clog2(NUM_INPUTS);

  logic unusedSelBits;
  assign unusedSelBits = ^sel;

  // flag bit picks the gate file; else the low bits index the inputs
  assign bitOut = sel[SW] ? gateBits[sel[GW-1:0]] : inBits[sel[IW-1:0]];
endmodule

// File: rtl/nor2_eval_ctrl.sv
module nor2_eval_ctrl
  import nor2_eval_pkg::*;
#(
  parameter int NUM_GATES = 64,
  localparam int GW = $clog2(NUM_GATES),
  localparam int CW = $clog2(NUM_GATES + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic          cfgCountWe,
  input  logic [CW-1:0] cfgCountVal,
  output nor2Strobes_t  strobes,
  output logic [GW-1:0] gateIdx,
  output logic [CW-1:0] gateCount,
  output logic          busy,
  output logic          done
);
  nor2SeqState_t state;
  logic          accept;
  logic          lastGate;
  logic          doneReg;

  assign accept   = (state == SEQ_IDLE) && start && (gateCount != '0);
  assign lastGate = (state == SEQ_RUN) && (CW'(gateIdx) == gateCount - 1'b1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= SEQ_IDLE;
      gateIdx   <= '0;
      gateCount <= '0;
      doneReg   <= 1'b0;
    end else begin
      doneReg <= 1'b0;
      case (state)
        SEQ_IDLE: begin
          if (cfgCountWe && (cfgCountVal <= CW'(NUM_GATES)))
            gateCount <= cfgCountVal;
          if (accept) begin
            state   <= SEQ_RUN;
            gateIdx <= '0;
          end
        end
        SEQ_RUN: begin
          if (lastGate) begin
            state   <= SEQ_IDLE;
            gateIdx <= '0;
            doneReg <= 1'b1;
          end else begin
            gateIdx <= gateIdx + 1'b1;
          end
        end
      endcase
    end
  end

  always_comb begin
    strobes.capture = accept;
    strobes.evalEn  = (state == SEQ_RUN);
    strobes.finish  = lastGate;
    strobes.cfgLock = (state == SEQ_RUN);
  end

  assign busy = (state == SEQ_RUN);
  assign done = doneReg;
endmodule

// File: rtl/nor2_eval_datapath.sv
module nor2_eval_datapath
  import nor2_eval_pkg::*;
#(
  parameter int NUM_GATES   = 64,
  parameter int NUM_INPUTS  = 16,
  parameter int NUM_OUTPUTS = 8,
  localparam int GW   = $clog2(NUM_GATES),
  localparam int IW   = $clog2(NUM_INPUTS),
  localparam int SW   = maxOf(GW, IW),
  localparam int SELW = SW + 1,
  localparam int OSW  = $clog2(NUM_OUTPUTS)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  nor2Strobes_t           strobes,
  input  logic [GW-1:0]          gateIdx,
  input  logic                   cfgGateWe,
  input  logic [GW-1:0]          cfgGateAddr,
  input  logic [SELW-1:0]        cfgSrcA,
  input  logic [SELW-1:0]        cfgSrcB,
  input  logic                   cfgMapWe,
  input  logic [OSW-1:0]         cfgMapSlot,
  input  logic [GW-1:0]          cfgMapGate,
  input  logic [NUM_INPUTS-1:0]  inVec,
  output logic [NUM_OUTPUTS-1:0] outVec
);
  logic [SELW-1:0]        srcATab [NUM_GATES];
  logic [SELW-1:0]        srcBTab [NUM_GATES];
  logic [GW-1:0]          outMap  [NUM_OUTPUTS];
  logic [NUM_INPUTS-1:0]  inReg;
  logic [NUM_GATES-1:0]   valueFile;
  logic [NUM_OUTPUTS-1:0] outReg;
  logic [NUM_OUTPUTS-1:0] laneNext;
  logic                   opA;
  logic                   opB;
  logic                   norOut;

  // gate table
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int g = 0; g < NUM_GATES; g++) begin
        srcATab[g] <= '0;
        srcBTab[g] <= '0;
      end
    end else if (cfgGateWe && !strobes.cfgLock) begin
      srcATab[cfgGateAddr] <= cfgSrcA;
      srcBTab[cfgGateAddr] <= cfgSrcB;
    end
  end

  // output map
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < NUM_OUTPUTS; k++) outMap[k] <= '0;
    end else if (cfgMapWe && !strobes.cfgLock) begin
      outMap[cfgMapSlot] <= cfgMapGate;
    end
  end

  // input capture
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                inReg <= '0;
    else if (strobes.capture) inReg <= inVec;
  end

  // shared operator: fetch both operands, one NOR
  nor2_eval_operand #(
    .NUM_GATES(NUM_GATES), .NUM_INPUTS(NUM_INPUTS), .SW(SW)
  ) u_opA (
    .sel(srcATab[gateIdx]), .inBits(inReg), .gateBits(valueFile), .bitOut(opA)
  );

  nor2_eval_operand #(
    .NUM_GATES(NUM_GATES), .NUM_INPUTS(NUM_INPUTS), .SW(SW)
  ) u_opB (
    .sel(srcBTab[gateIdx]), .inBits(inReg), .gateBits(valueFile), .bitOut(opB)
  );

  assign norOut = ~(opA | opB);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               valueFile <= '0;
    else if (strobes.evalEn) valueFile[gateIdx] <= norOut;
  end

  // output lanes forward the result being written on the final cycle
  for (genvar k = 0; k < NUM_OUTPUTS; k++) begin : g_lane
    assign laneNext[k] = (outMap[k] == gateIdx) ? norOut : valueFile[outMap[k]];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               outReg <= '0;
    else if (strobes.finish) outReg <= laneNext;
  end

  assign outVec = outReg;
endmodule

// File: rtl/nor2_eval.sv
module nor2_eval
  import nor2_eval_pkg::*;
#(
  parameter int NUM_GATES   = 64,
  parameter int NUM_INPUTS  = 16,
  parameter int NUM_OUTPUTS = 8,
  localparam int GW   = $clog2(NUM_GATES),
  localparam int IW   = $clog2(NUM_INPUTS),
  localparam int SW   = maxOf(GW, IW),
  localparam int SELW = SW + 1,
  localparam int CW   = $clog2(NUM_GATES + 1),
  localparam int OSW  = $clog2(NUM_OUTPUTS)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   cfgGateWe,
  input  logic [GW-1:0]          cfgGateAddr,
  input  logic [SELW-1:0]        cfgSrcA,
  input  logic [SELW-1:0]        cfgSrcB,
  input  logic                   cfgCountWe,
  input  logic [CW-1:0]          cfgCountVal,
  input  logic                   cfgMapWe,
  input  logic [OSW-1:0]         cfgMapSlot,
  input  logic [GW-1:0]          cfgMapGate,
  input  logic                   start,
  input  logic [NUM_INPUTS-1:0]  inVec,
  output logic                   busy,
  output logic                   done,
  output logic [NUM_OUTPUTS-1:0] outVec
);
  nor2Strobes_t  strobes;
  logic [GW-1:0] gateIdx;
  logic [CW-1:0] gateCount;

  nor2_eval_ctrl #(.NUM_GATES(NUM_GATES)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start),
    .cfgCountWe(cfgCountWe), .cfgCountVal(cfgCountVal),
    .strobes(strobes), .gateIdx(gateIdx), .gateCount(gateCount),
    .busy(busy), .done(done)
  );

  nor2_eval_datapath #(
    .NUM_GATES(NUM_GATES), .NUM_INPUTS(NUM_INPUTS), .NUM_OUTPUTS(NUM_OUTPUTS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .gateIdx(gateIdx),
    .cfgGateWe(cfgGateWe), .cfgGateAddr(cfgGateAddr),
    .cfgSrcA(cfgSrcA), .cfgSrcB(cfgSrcB),
    .cfgMapWe(cfgMapWe), .cfgMapSlot(cfgMapSlot), .cfgMapGate(cfgMapGate),
    .inVec(inVec), .outVec(outVec)
  );
endmodule

// File: rtl/nor2_eval_checker.sv
module nor2_eval_checker #(
  parameter int NUM_GATES   = 64,
  parameter int NUM_OUTPUTS = 8,
  localparam int GW = $clog2(NUM_GATES),
  localparam int CW = $clog2(NUM_GATES + 1)
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   start,
  input logic                   busy,
  input logic                   done,
  input logic [NUM_OUTPUTS-1:0] outVec,
  input logic [GW-1:0]          gateIdx,
  input logic [CW-1:0]          gateCount
);
  logic [CW-1:0] runLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     runLen <= '0;
    else if (busy) runLen <= runLen + 1'b1;
    else           runLen <= '0;
  end

  assert_run_length_R4: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (runLen == gateCount));

  assert_done_single_R4: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_done_after_busy_R4: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && $past(busy)));

  assert_accept_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start && (gateCount != '0)) |=> (busy && (gateIdx == '0)));

  assert_zero_count_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start && (gateCount == '0)) |=> !busy);

  assert_index_step_R5: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> (gateIdx == GW'($past(gateIdx) + 1'b1)));

  assert_index_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (CW'(gateIdx) < gateCount));

  assert_out_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> $stable(outVec));

  assert_count_frozen_R8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(gateCount));
endmodule

bind nor2_eval nor2_eval_checker #(
  .NUM_GATES(NUM_GATES), .NUM_OUTPUTS(NUM_OUTPUTS)
) u_nor2_eval_checker (
  .clk(clk), .rstN(rstN), .start(start), .busy(busy), .done(done),
  .outVec(outVec), .gateIdx(gateIdx), .gateCount(gateCount)
);

// File: tb/nor2_eval_bench.sv
module nor2_eval_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgGateWe = 1'b0;
  logic [5:0]  cfgGateAddr = '0;
  logic [6:0]  cfgSrcA = '0;
  logic [6:0]  cfgSrcB = '0;
  logic        cfgCountWe = 1'b0;
  logic [6:0]  cfgCountVal = '0;
  logic        cfgMapWe = 1'b0;
  logic [2:0]  cfgMapSlot = '0;
  logic [5:0]  cfgMapGate = '0;
  logic        start = 1'b0;
  logic [15:0] inVec = '0;
  logic        busy;
  logic        done;
  logic [7:0]  outVec;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 0;

  // bench-side model of the configuration and gate values
  logic [6:0] tbA [64];
  logic [6:0] tbB [64];
  logic [5:0] tbMap [8];
  int         tbCount = 0;
  logic       mv [64];
  logic [15:0] lfsr = 16'hACE1;

  always #10 clk = ~clk;

  nor2_eval u_nor2_eval (
    .clk(clk), .rstN(rstN),
    .cfgGateWe(cfgGateWe), .cfgGateAddr(cfgGateAddr),
    .cfgSrcA(cfgSrcA), .cfgSrcB(cfgSrcB),
    .cfgCountWe(cfgCountWe), .cfgCountVal(cfgCountVal),
    .cfgMapWe(cfgMapWe), .cfgMapSlot(cfgMapSlot), .cfgMapGate(cfgMapGate),
    .start(start), .inVec(inVec),
    .busy(busy), .done(done), .outVec(outVec)
  );

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
  end

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic srcVal(input logic [6:0] s, input logic [15:0] v);
    return s[6] ? mv[s[5:0]] : v[s[3:0]];
  endfunction

  task automatic modelRun(input logic [15:0] v, output logic [7:0] exp);
    for (int g = 0; g < tbCount; g++)
      mv[g] = ~(srcVal(tbA[g], v) | srcVal(tbB[g], v));
    for (int k = 0; k < 8; k++) exp[k] = mv[tbMap[k]];
  endtask

  task automatic writeGate(input int g, input logic [6:0] a, input logic [6:0] b);
    @(negedge clk);
    cfgGateWe = 1; cfgGateAddr = 6'(g); cfgSrcA = a; cfgSrcB = b;
    @(negedge clk);
    cfgGateWe = 0;
    tbA[g] = a; tbB[g] = b;
  endtask

  task automatic writeMap(input int k, input int g);
    @(negedge clk);
    cfgMapWe = 1; cfgMapSlot = 3'(k); cfgMapGate = 6'(g);
    @(negedge clk);
    cfgMapWe = 0;
    tbMap[k] = 6'(g);
  endtask

  task automatic writeCount(input int n);
    @(negedge clk);
    cfgCountWe = 1; cfgCountVal = 7'(n);
    @(negedge clk);
    cfgCountWe = 0;
    if (n <= 64) tbCount = n;  // R6: larger values are dropped
  endtask

  // mode 0 plain, 1 input pins change mid-run, 2 start mid-run, 3 config writes mid-run
  task automatic runCheck(input logic [15:0] v, input int mode, input string req);
    logic [7:0] exp;
    int cycles;
    modelRun(v, exp);
    @(negedge clk);
    inVec = v; start = 1;
    @(negedge clk);
    start = 0;
    cycles = 0;
    while (busy && cycles < 100) begin
      start       = (mode == 2) && (cycles == 1);
      cfgGateWe   = (mode == 3) && (cycles == 1);
      cfgCountWe  = (mode == 3) && (cycles == 1);
      cfgMapWe    = (mode == 3) && (cycles == 1);
      cfgGateAddr = 6'd0; cfgSrcA = 7'h40; cfgSrcB = 7'h41;
      cfgCountVal = 7'd1; cfgMapSlot = 3'd0; cfgMapGate = 6'd1;
      if (mode == 1 || mode == 2) inVec = ~v;
      cycles++;
      @(negedge clk);
    end
    start = 0; cfgGateWe = 0; cfgCountWe = 0; cfgMapWe = 0;
    check("R4", "busy cycles", cycles, tbCount);
    check("R4", "done after run", done, 1);
    check("R4", "busy low with done", busy, 0);
    check(req, "output bus", outVec, exp);
    @(negedge clk);
    check("R4", "done one cycle", done, 0);
    check("R5", "no extra run", busy, 0);
    check("R7", "output held", outVec, exp);
  endtask

  task automatic testReset();
    check("R7", "reset outVec", outVec, 0);
    check("R4", "reset busy", busy, 0);
    check("R4", "reset done", done, 0);
  endtask

  task automatic testZeroCount();
    int seen = 0;
    @(negedge clk);
    start = 1; inVec = 16'hFFFF;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      start = 0;
      if (busy || done) seen++;
    end
    check("R6", "count zero refuses start", seen, 0);
  endtask

  task automatic programSmall();
    writeGate(0, 7'h00, 7'h01);           // NOR(I0,I1)
    writeGate(1, 7'h00, 7'h40);           // NOR(I0,g0)
    writeGate(2, 7'h11, 7'h40);           // R1: index 0x11 selects I1
    writeGate(3, 7'h41, 7'h42);           // XNOR of I0,I1
    writeGate(4, 7'h43, 7'h43);           // XOR of I0,I1
    writeCount(5);
    writeMap(0, 4); writeMap(1, 3); writeMap(2, 0); writeMap(3, 1);
    writeMap(4, 2); writeMap(5, 4); writeMap(6, 0); writeMap(7, 40);
  endtask

  task automatic testSmall();
    runCheck(16'h0000, 0, "R9");
    check("R9", "unevaluated gate 40", outVec[7], 0);
    for (int v = 0; v < 4; v++) begin
      runCheck(16'(v), 0, "R1");
      check("R2", "xor chain", outVec[0], v[0] ^ v[1]);
    end
  endtask

  task automatic testInputChange();
    runCheck(16'h0001, 1, "R3");
  endtask

  task automatic testStartWhileBusy();
    runCheck(16'h0002, 2, "R5");
  endtask

  task automatic testCountOverflow();
    writeCount(65);
    runCheck(16'h0003, 0, "R6");
  endtask

  task automatic testBusyWrites();
    runCheck(16'h0001, 3, "R8");
    runCheck(16'h0002, 0, "R8");
  endtask

  task automatic testBig();
    for (int g = 0; g < 64; g++) begin
      logic [6:0] a, b;
      for (int s = 0; s < 2; s++) begin
        logic [6:0] sel;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        if (g == 0 || lfsr[0]) sel = {1'b0, lfsr[6:1]};
        else sel = {1'b1, 6'(int'(lfsr[15:4]) % g)};
        if (s == 0) a = sel; else b = sel;
      end
      writeGate(g, a, b);
    end
    writeCount(64);
    for (int k = 0; k < 8; k++) writeMap(k, 63 - 5 * k);
    for (int i = 0; i < 6; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      runCheck(lfsr, 0, "R2");
    end
  endtask

  task automatic testSingleGate();
    writeCount(1);
    writeMap(0, 0);
    runCheck(16'h0000, 0, "R2");
    runCheck(16'hFFFF, 0, "R2");
  endtask

  initial begin
    for (int g = 0; g < 64; g++) begin tbA[g] = 0; tbB[g] = 0; mv[g] = 0; end
    for (int k = 0; k < 8; k++) tbMap[k] = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    testReset();
    testZeroCount();
    programSmall();
    testSmall();
    testInputChange();
    testStartWhileBusy();
    testCountOverflow();
    testBusyWrites();
    testBig();
    testSingleGate();
    summary();
  end
endmodule